// File: doc/BRIEF.md
# Condition Test and Status Flag Update

This block belongs to the control path of a small 16-bit processor. It does two jobs. First, it decides whether a conditional-load instruction may write its destination register. Second, it computes and holds the next values of four status flags: sign S, nonzero N, carry K and overflow V.

For the condition test, a 4-bit modifier acts as a truth table over a pair of flags. When op is 0 the pair is (S,N); when op is 1 the pair is (K,V). The flag bits form an index from 0 to 3, and the modifier bit at that index is the test result. An instruction that is not conditional always gets a change of 1.

The flags are written from an 18-bit ALU result word:

- bits 15:0 are the data;
- bit 16 is the carry out;
- bit 17 is the overflow.

The flags hold their value during conditional loads, jumps and the first cycle of an indirect fetch. The carry and overflow flags also hold for logical operations. For add or subtract with carry, the nonzero flag stays set once it has been set, so that a multiword value that is zero only in its upper word still reads as nonzero. A run input clears all flags on the clock edge while it is low.

Top module: `cond_flag_unit`

## Requirements
- R1: When `cond_i` is 0, `change_o` is 1 in the same cycle, whatever the other inputs are.
- R2: When `cond_i` is 1 and `op_i` is 0, `change_o` equals `mod_i[{S,N}]`. Here S is the index high bit, and S and N are the registered flags `flags_o[3]` and `flags_o[2]`.
- R3: When `cond_i` is 1 and `op_i` is 1, `change_o` equals `mod_i[{K,V}]`. Here K is `flags_o[1]` and is the index high bit, and V is `flags_o[0]`.
- R4: When `run_i` is 1 on a rising edge and any of `cond_i`, `jump_i` or `ind_i` is 1, S and N keep their values.
- R5: When `run_i` is 1 and `cond_i`, `jump_i` and `ind_i` are all 0, S takes `result_i[15]` on the rising edge.
- R6: Under the same update condition as R5, N becomes 1 if any of `result_i[15:0]` is 1, and 0 otherwise, except as R7 adds.
- R7: When the update condition of R5 holds and the operation is add or subtract with carry (`op_i`=1, `mod_i[3]`=1, `mod_i[2]`=0, `mod_i[0]`=1), N also becomes 1 if the old N or the old S was 1.
- R8: When `run_i` is 1, K and V keep their values if `op_i` is 0 or if any of `cond_i`, `jump_i` or `ind_i` is 1.
- R9: When `run_i` is 1, `op_i` is 1 and `cond_i`, `jump_i` and `ind_i` are all 0, K takes `result_i[16]` and V takes `result_i[17]`.
- R10: A rising edge with `run_i` at 0 sets all four flags to 0. The flag output is packed as {S,N,K,V}, with S in bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| run_i | input | 1 | Run enable; while low, the flags clear on the edge |
| op_i | input | 1 | Operation class: 0 = logic or (S,N) test, 1 = arithmetic or (K,V) test |
| mod_i | input | 4 | Modifier truth table / operation selector |
| cond_i | input | 1 | Instruction is a conditional load |
| jump_i | input | 1 | Instruction is a jump |
| ind_i | input | 1 | First cycle of an indirect operand fetch |
| result_i | input | 18 | ALU result {overflow, carry, data[15:0]} |
| change_o | output | 1 | Destination may be written |
| flags_o | output | 4 | Registered flags {S,N,K,V} |

## Verification
The assertions assume that every input is at a known 0 or 1 on every rising edge. They also assume that the first edges of a run come with `run_i` low, so the flags start from a cleared state rather than an unknown one. The stimulus starts with a few cycles of run low and changes inputs only on falling edges. After that it drives random values, biased so that hold conditions, all-zero results and the chained-carry opcode all occur often. Run is dropped at random points, so the clear and the restart are exercised repeatedly.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  typedef struct packed {
    logic s;
    logic n;
    logic k;
    logic v;
  } flags_t;

  localparam int PAIR_CNT = 2;
  localparam int MOD_W    = 4;
endpackage

// File: rtl/cfu_pair_test.sv
module cfu_pair_test #(
  parameter int MOD_W = 4
) (
  input  logic [MOD_W-1:0] mod_i,
  input  logic             hi_i,
  input  logic             lo_i,
  output logic             hit_o
);
  logic [MOD_W-1:0] term;

  generate
    for (genvar i = 0; i < MOD_W; i++) begin : g_term
      assign term[i] = mod_i[i] & ({hi_i, lo_i} == 2'(i));
    end
  endgenerate

  assign hit_o = |term;
endmodule

// File: rtl/cfu_cond.sv
module cfu_cond
  import cfu_pkg::*;
(
  input  flags_t           flags_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic             op_i,
  input  logic             cond_i,
  output logic             change_o
);
  logic [PAIR_CNT-1:0] hi;
  logic [PAIR_CNT-1:0] lo;
  logic [PAIR_CNT-1:0] hit;

  assign hi = {flags_i.k, flags_i.s};
  assign lo = {flags_i.v, flags_i.n};

  generate
    for (genvar p = 0; p < PAIR_CNT; p++) begin : g_pair
      cfu_pair_test #(.MOD_W(MOD_W)) u_test (
        .mod_i (mod_i),
        .hi_i  (hi[p]),
        .lo_i  (lo[p]),
        .hit_o (hit[p])
      );
    end
  endgenerate

  assign change_o = !cond_i | (hit[0] & !op_i) | (hit[1] & op_i);
endmodule

// File: rtl/cfu_flag_next.sv
module cfu_flag_next
  import cfu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  flags_t            cur_i,
  input  logic [DATA_W+1:0] result_i,
  input  logic [MOD_W-1:0]  mod_i,
  input  logic              op_i,
  input  logic              cond_i,
  input  logic              jump_i,
  input  logic              ind_i,
  input  logic              run_i,
  output flags_t            nxt_o
);
  localparam int CARRY_BIT = DATA_W;
  localparam int OVF_BIT   = DATA_W + 1;

  logic   hold;
  logic   chain;
  logic   any_one;
  flags_t upd;

  assign hold    = cond_i | jump_i | ind_i;
  assign chain   = op_i & mod_i[3] & !mod_i[2] & mod_i[0];
  assign any_one = |result_i[DATA_W-1:0];

  always_comb begin
    upd   = cur_i;
    upd.s = hold ? cur_i.s : result_i[DATA_W-1];
    upd.n = hold ? cur_i.n : (any_one | (chain & (cur_i.n | cur_i.s)));
    if (!hold && op_i) begin
      upd.k = result_i[CARRY_BIT];
      upd.v = result_i[OVF_BIT];
    end
  end

  assign nxt_o = run_i ? upd : flags_t'('0);
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              run_i,
  input  logic              op_i,
  input  logic [3:0]        mod_i,
  input  logic              cond_i,
  input  logic              jump_i,
  input  logic              ind_i,
  input  logic [DATA_W+1:0] result_i,
  output logic              change_o,
  output logic [3:0]        flags_o
);
  flags_t flag_q;
  flags_t flag_d;
  logic   primed_q = 1'b0;

  cfu_cond u_cond (
    .flags_i  (flag_q),
    .mod_i    (mod_i),
    .op_i     (op_i),
    .cond_i   (cond_i),
    .change_o (change_o)
  );

  cfu_flag_next #(.DATA_W(DATA_W)) u_next (
    .cur_i    (flag_q),
    .result_i (result_i),
    .mod_i    (mod_i),
    .op_i     (op_i),
    .cond_i   (cond_i),
    .jump_i   (jump_i),
    .ind_i    (ind_i),
    .run_i    (run_i),
    .nxt_o    (flag_d)
  );

  always_ff @(posedge clk) begin
    flag_q <= flag_d;
    if (!run_i) primed_q <= 1'b1;
  end

  assign flags_o = flag_q;

  // R1
  unconditional_change_chk: assert property (@(posedge clk) disable iff (!primed_q)
    !cond_i |-> change_o);

  // R4
  sn_hold_chk: assert property (@(posedge clk) disable iff (!primed_q)
    (run_i && (cond_i || jump_i || ind_i)) |=> $stable(flags_o[3:2]));

  // R8
  kv_hold_chk: assert property (@(posedge clk) disable iff (!primed_q)
    (run_i && (!op_i || cond_i || jump_i || ind_i)) |=> $stable(flags_o[1:0]));

  // R7
  chain_nonzero_chk: assert property (@(posedge clk) disable iff (!primed_q)
    (run_i && !cond_i && !jump_i && !ind_i && op_i && mod_i[3] && !mod_i[2]
     && mod_i[0] && (flags_o[3] || flags_o[2])) |=> flags_o[2]);

  // R10
  run_clear_chk: assert property (@(posedge clk)
    !run_i |=> (flags_o == 4'b0000));
endmodule

// File: tb/tb_cond_flag_unit.sv
module tb_cond_flag_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int NCYC = 3000;

  logic clk = 1'b0;
  logic run_i = 1'b0, op_i = 1'b0, cond_i = 1'b0, jump_i = 1'b0, ind_i = 1'b0;
  logic [3:0] mod_i = '0;
  logic [DATA_W+1:0] result_i = '0;
  logic change_o;
  logic [3:0] flags_o;

  int n_cmp = 0, n_bad = 0;
  int ms = 0, mn = 0, mk = 0, mv = 0;
  string ts = "R10", tn = "R10", tk = "R10", tv = "R10";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_flag_unit #(.DATA_W(DATA_W)) dut (
    .clk(clk), .run_i(run_i), .op_i(op_i), .mod_i(mod_i), .cond_i(cond_i),
    .jump_i(jump_i), .ind_i(ind_i), .result_i(result_i),
    .change_o(change_o), .flags_o(flags_o));

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit o, input bit [3:0] m, input bit c,
                      input bit j, input bit i, input bit [DATA_W+1:0] res);
    int exp_ch, hold, chain;
    @(negedge clk);
    // flags settled after the previous edge
    cmp(ts, flags_o[3], ms); cmp(tn, flags_o[2], mn);
    cmp(tk, flags_o[1], mk); cmp(tv, flags_o[0], mv);
    run_i = r; op_i = o; mod_i = m; cond_i = c; jump_i = j; ind_i = i; result_i = res;
    #1;
    if (!c) exp_ch = 1;
    else if (!o) exp_ch = m[ms*2+mn];
    else exp_ch = m[mk*2+mv];
    cmp(!c ? "R1" : (o ? "R3" : "R2"), change_o, exp_ch);
    hold  = c | j | i;
    chain = o & m[3] & !m[2] & m[0];
    if (!r) begin
      ms = 0; mn = 0; mk = 0; mv = 0;
      ts = "R10"; tn = "R10"; tk = "R10"; tv = "R10";
    end else begin
      if (hold) begin ts = "R4"; tn = "R4"; end
      else begin
        ts = "R5"; tn = (chain && (ms || mn)) ? "R7" : "R6";
        mn = ((res[DATA_W-1:0] != 0) || (chain && (ms || mn))) ? 1 : 0;
        ms = res[DATA_W-1];
      end
      if (hold || !o) begin tk = "R8"; tv = "R8"; end
      else begin tk = "R9"; tv = "R9"; mk = res[DATA_W]; mv = res[DATA_W+1]; end
    end
  endtask

  initial begin
    repeat (3) step(0, 0, 4'h0, 0, 0, 0, '0);
    // directed: set S and N, then test, then chained carry with zero result
    step(1, 0, 4'hF, 0, 0, 0, 18'h0_8001);
    step(1, 1, 4'h8, 0, 0, 0, 18'h3_0000);
    step(1, 0, 4'h8, 1, 0, 0, '0);
    step(1, 1, 4'h8, 1, 0, 0, '0);
    step(1, 1, 4'h9, 0, 0, 0, '0);
    step(1, 1, 4'h9, 0, 0, 0, '0);
    step(1, 1, 4'hB, 0, 0, 0, '0);
    step(1, 0, 4'hF, 0, 1, 0, '0);
    step(1, 0, 4'hF, 0, 0, 1, '0);
    step(0, 1, 4'hF, 0, 0, 0, 18'h3_FFFF);
    for (int t = 0; t < NCYC; t++) begin
      bit [DATA_W+1:0] res;
      res = 18'($urandom);
      if ($urandom_range(3) == 0) res[DATA_W-1:0] = '0;
      step($urandom_range(15) != 0, 1'($urandom), 4'($urandom),
           $urandom_range(2) == 0, $urandom_range(5) == 0,
           $urandom_range(5) == 0, res);
    end
    step(1, 0, 4'h0, 0, 0, 0, '0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (NCYC + 1000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule